// File: doc/BRIEF.md
# PFC Protection Supervisor

This block qualifies the switching gate of a power-factor-correction stage against the fault flags that the analog front end raises. It is fully synchronous. Every comparator flag (line sense low, line sense above its enable level, feedback low, overvoltage per channel, overvoltage clear per channel, and peak current) first passes through a multi-stage synchronizer. The PWM request comes from the same clock domain and is used as it is.

Line brown-out and an open feedback loop both put the controller into standby. In standby the gate is blocked and a compensation-discharge request is raised. After reset the block stays in standby until the line has crossed its enable level and the feedback is above its open-loop threshold.

Overvoltage is handled separately by a latch that blocks only the gate. It is set by any channel and released only when every channel reports it is below the lower reset level. A peak-current flag cuts the gate cycle by cycle, except during a programmable blanking window that starts at each rising edge of the PWM request. The final gate is registered.

Top module: `pfc_prot_supervisor`

## Requirements
- R1: After reset `standby_o`=1, `comp_dis_o`=1 and `gate_o`=0. Standby persists until the line sense is above its enable level (`line_en_i`=1) and the feedback is above its open-loop threshold (`fb_low_i`=0). The gate is never high while standby is high.
- R2: A line brown-out flag (`line_low_i`=1) forces standby, raises the compensation discharge and drops the gate.
- R3: Brown-out standby ends only once `line_en_i`=1. With the line between the two thresholds (`line_low_i`=0, `line_en_i`=0) the block stays in standby.
- R4: An open-loop flag (`fb_low_i`=1) forces standby, raises the compensation discharge and drops the gate.
- R5: Open-loop standby has no hysteresis. If no brown-out is latched, standby ends as soon as `fb_low_i` returns to 0, even while the line sits between its two thresholds.
- R6: Any overvoltage channel (`ov_hi_i[c]`=1, bit c = channel c) drops the gate. Overvoltage alone neither enters standby nor raises compensation discharge.
- R7: After overvoltage the gate stays blocked until every channel reports below its reset level (`ov_clr_i` all ones). A subset of cleared channels keeps it blocked.
- R8: Outside blanking, a peak-current flag (`pk_i`=1) holds the gate low for as long as it persists. The gate returns once the flag clears.
- R9: The peak-current flag is ignored for `blank_len_i` clock cycles, counted from the cycle in which `pwm_req_i` rises. A value of 0 disables blanking. Every new rising edge re-arms the window.
- R10: With no fault active, `gate_o` equals `pwm_req_i` delayed by one clock.
- R11: A change on any comparator flag reaches the outputs on the third rising clock edge after it is applied: two synchronizer stages plus the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_low_i | input | 1 | Line sense below brown-out threshold (async) |
| line_en_i | input | 1 | Line sense above enable level (async) |
| fb_low_i | input | 1 | Feedback below open-loop threshold (async) |
| ov_hi_i | input | OV_CH | Per-channel overvoltage above threshold (async) |
| ov_clr_i | input | OV_CH | Per-channel below overvoltage reset level (async) |
| pk_i | input | 1 | Peak current above limit (async) |
| blank_len_i | input | BLANK_W | Blanking window length in clock cycles |
| pwm_req_i | input | 1 | Gate request from the PWM modulator (synchronous) |
| gate_o | output | 1 | Qualified, registered gate drive |
| comp_dis_o | output | 1 | Compensation-discharge request |
| standby_o | output | 1 | Standby-mode indicator |

## Verification
The bench drives the line through the zone between its two thresholds after a brown-out and after an open-loop fault. A design without hysteresis would leave standby too early after a brown-out, and one that shared the brown-out latch with open-loop would stay stuck after an open-loop fault. Each overvoltage channel is raised in turn and then cleared one channel at a time; a design that released on a single cleared channel would restart the gate too soon. Blanking lengths 0 to 6 are swept against every peak-current arrival offset from 0 to 6 cycles. An off-by-one window, or a window that is not re-armed on each rising edge, would show up as a gate edge landing one cycle early or late.

// File: rtl/pfc_prot_pkg.sv
package pfc_prot_pkg;
   // Synchronized line/feedback comparator group
   typedef struct packed {
      logic line_low;
      logic line_en;
      logic fb_low;
      logic pk;
   } lf_flags_t;

   localparam int LF_W = $bits(lf_flags_t);
endpackage

// File: rtl/pfc_sync.sv
module pfc_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pfc_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("pfc_sync: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pfc_standby_ctl.sv
module pfc_standby_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic line_low_s,
   input  logic line_en_s,
   input  logic fb_low_s,
   output logic standby_nxt,
   output logic standby_q
);
   logic bo_lat_q, bo_lat_nxt;

   // Brown-out latch: set by low line, cleared only at the enable level
   always_comb begin
      bo_lat_nxt = bo_lat_q;
      if (line_low_s)     bo_lat_nxt = 1'b1;
      else if (line_en_s) bo_lat_nxt = 1'b0;
      standby_nxt = bo_lat_nxt | fb_low_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bo_lat_q  <= 1'b1;
         standby_q <= 1'b1;
      end else begin
         bo_lat_q  <= bo_lat_nxt;
         standby_q <= standby_nxt;
      end
   end

   assert_brownout_enters_R2: assert property (@(posedge clk) disable iff (!rst_n)
      line_low_s |=> standby_q);
   assert_hyst_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bo_lat_q && !line_en_s) |=> standby_q);
   assert_openloop_enters_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fb_low_s |=> standby_q);
endmodule

// File: rtl/pfc_ovp_latch.sv
module pfc_ovp_latch #(
   parameter int CH = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CH-1:0] ov_hi_s,
   input  logic [CH-1:0] ov_clr_s,
   output logic          ov_nxt,
   output logic          ov_q
);
   generate
      if (CH < 1) begin : g_bad_ch
         $error("pfc_ovp_latch: CH must be at least 1");
      end
   endgenerate

   logic any_hi, all_clr;

   always_comb begin
      any_hi  = |ov_hi_s;
      all_clr = &ov_clr_s;
      ov_nxt  = ov_q;
      if (any_hi)       ov_nxt = 1'b1;
      else if (all_clr) ov_nxt = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ov_q <= 1'b0;
      else        ov_q <= ov_nxt;
   end

   assert_any_channel_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ov_hi_s != '0) |=> ov_q);
   assert_release_needs_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ov_q && !(&ov_clr_s)) |=> ov_q);
endmodule

// File: rtl/pfc_leb.sv
module pfc_leb #(
   parameter int W      = 8,
   parameter bit LEB_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pwm_req,
   input  logic [W-1:0] blank_len,
   output logic         blank_act
);
   generate
      if (W < 1) begin : g_bad_w
         $error("pfc_leb: W must be at least 1");
      end

      if (LEB_EN) begin : g_leb
         logic         pwm_q;
         logic [W-1:0] cnt_q;
         logic         rise;

         always_comb begin
            rise      = pwm_req & ~pwm_q;
            blank_act = (rise && (blank_len != '0)) || (cnt_q != '0);
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pwm_q <= 1'b0;
               cnt_q <= '0;
            end else begin
               pwm_q <= pwm_req;
               if (!pwm_req)
                  cnt_q <= '0;
               else if (rise)
                  cnt_q <= (blank_len != '0) ? blank_len - 1'b1 : '0;
               else if (cnt_q != '0)
                  cnt_q <= cnt_q - 1'b1;
            end
         end

         assert_window_rearms_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(pwm_req) && (blank_len > 1)) |=> blank_act);
      end else begin : g_no_leb
         logic unused_in;
         assign unused_in = ^{clk, rst_n, pwm_req, blank_len};
         assign blank_act = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pfc_prot_supervisor.sv
module pfc_prot_supervisor
   import pfc_prot_pkg::*;
#(
   parameter int OV_CH       = 2,
   parameter int BLANK_W     = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit LEB_EN      = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               line_low_i,
   input  logic               line_en_i,
   input  logic               fb_low_i,
   input  logic [OV_CH-1:0]   ov_hi_i,
   input  logic [OV_CH-1:0]   ov_clr_i,
   input  logic               pk_i,
   input  logic [BLANK_W-1:0] blank_len_i,
   input  logic               pwm_req_i,
   output logic               gate_o,
   output logic               comp_dis_o,
   output logic               standby_o
);
   localparam int OV_VEC_W = 2 * OV_CH;

   lf_flags_t             lf_raw, lf_s;
   logic [OV_VEC_W-1:0]   ov_raw, ov_s;
   logic                  standby_nxt, standby_q;
   logic                  ov_nxt, ov_q;
   logic                  blank_act;
   logic                  pk_hit;
   logic                  gate_q;

   assign lf_raw = '{line_low: line_low_i, line_en: line_en_i,
                     fb_low: fb_low_i, pk: pk_i};
   assign ov_raw = {ov_clr_i, ov_hi_i};

   pfc_sync #(.W(LF_W), .STAGES(SYNC_STAGES)) u_sync_lf (
      .clk(clk), .rst_n(rst_n), .d_i(lf_raw), .q_o(lf_s));

   pfc_sync #(.W(OV_VEC_W), .STAGES(SYNC_STAGES)) u_sync_ov (
      .clk(clk), .rst_n(rst_n), .d_i(ov_raw), .q_o(ov_s));

   pfc_standby_ctl u_stby (
      .clk(clk), .rst_n(rst_n),
      .line_low_s(lf_s.line_low), .line_en_s(lf_s.line_en), .fb_low_s(lf_s.fb_low),
      .standby_nxt(standby_nxt), .standby_q(standby_q));

   pfc_ovp_latch #(.CH(OV_CH)) u_ovp (
      .clk(clk), .rst_n(rst_n),
      .ov_hi_s(ov_s[OV_CH-1:0]), .ov_clr_s(ov_s[OV_VEC_W-1:OV_CH]),
      .ov_nxt(ov_nxt), .ov_q(ov_q));

   pfc_leb #(.W(BLANK_W), .LEB_EN(LEB_EN)) u_leb (
      .clk(clk), .rst_n(rst_n), .pwm_req(pwm_req_i),
      .blank_len(blank_len_i), .blank_act(blank_act));

   assign pk_hit = lf_s.pk & ~blank_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gate_q <= 1'b0;
      else        gate_q <= pwm_req_i & ~standby_nxt & ~ov_nxt & ~pk_hit;
   end

   assign gate_o     = gate_q;
   assign standby_o  = standby_q;
   assign comp_dis_o = standby_q;

   assert_no_gate_in_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
      standby_q |-> !gate_q);
   assert_ov_blocks_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ov_q |-> !gate_q);
   assert_pk_cuts_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pk_hit |=> !gate_q);
   assert_gate_needs_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
      gate_q |-> $past(pwm_req_i));
endmodule

// File: tb/tb_pfc_prot_supervisor.sv
module tb_pfc_prot_supervisor;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       line_low, line_en, fb_low, pk, pwm;
   logic [1:0] ov_hi, ov_clr;
   logic [7:0] blank_len;
   logic       gate, comp_dis, standby;
   int         n_tests = 0, n_fail = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   pfc_prot_supervisor dut (
      .clk(clk), .rst_n(rst_n), .line_low_i(line_low), .line_en_i(line_en),
      .fb_low_i(fb_low), .ov_hi_i(ov_hi), .ov_clr_i(ov_clr), .pk_i(pk),
      .blank_len_i(blank_len), .pwm_req_i(pwm), .gate_o(gate),
      .comp_dis_o(comp_dis), .standby_o(standby));

   task automatic tick(input int n = 1);
      repeat (n) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic chk3(input string req, input logic g, input logic s);
      chk(req, "gate", gate, g);
      chk(req, "standby", standby, s);
      chk(req, "comp_dis", comp_dis, s);
   endtask

   initial begin
      rst_n = 1'b0; line_low = 0; line_en = 0; fb_low = 1; pk = 0; pwm = 0;
      ov_hi = 2'b00; ov_clr = 2'b11; blank_len = 8'd0;
      tick(3);
      rst_n = 1'b1;
      chk3("R1", 1'b0, 1'b1);

      // R1: start-up needs both line enable and feedback up
      pwm = 1; fb_low = 0;
      tick(8);
      chk3("R1", 1'b0, 1'b1);
      line_en = 1; fb_low = 1;
      tick(8);
      chk3("R1", 1'b0, 1'b1);
      fb_low = 0;
      tick(2);
      chk3("R11", 1'b0, 1'b1);
      tick(1);
      chk3("R1", 1'b1, 1'b0);

      // R10: request followed one clock later
      pwm = 0; tick(1); chk("R10", "gate", gate, 1'b0);
      pwm = 1; tick(1); chk("R10", "gate", gate, 1'b1);

      // R2/R3: brown-out and hysteresis
      line_low = 1; line_en = 0;
      tick(2); chk3("R11", 1'b1, 1'b0);
      tick(1); chk3("R2", 1'b0, 1'b1);
      line_low = 0;
      tick(8); chk3("R3", 1'b0, 1'b1);
      line_en = 1;
      tick(3); chk3("R3", 1'b1, 1'b0);

      // R4/R5: open loop, cleared with line between thresholds
      fb_low = 1;
      tick(3); chk3("R4", 1'b0, 1'b1);
      line_en = 0;
      tick(4); chk3("R4", 1'b0, 1'b1);
      fb_low = 0;
      tick(3); chk3("R5", 1'b1, 1'b0);
      line_en = 1;
      tick(3);

      // R6/R7: each overvoltage channel in turn
      for (int c = 0; c < 2; c++) begin
         ov_hi[c] = 1'b1; ov_clr[c] = 1'b0;
         tick(3); chk3("R6", 1'b0, 1'b0);
         ov_hi[c] = 1'b0;
         tick(5); chk("R7", "gate", gate, 1'b0);
         ov_clr[c] = 1'b1; ov_clr[1-c] = 1'b0;
         tick(5); chk("R7", "gate", gate, 1'b0);
         ov_clr = 2'b11;
         tick(3); chk3("R7", 1'b1, 1'b0);
      end

      // R8/R9: blanking length x peak-current arrival sweep
      for (int n = 0; n < 7; n++) begin
         for (int d = 0; d < 7; d++) begin
            pwm = 0; pk = 0; blank_len = 8'(n);
            tick(4);
            pwm = 1;
            for (int i = 0; i < 13; i++) begin
               if (i == d) pk = 1;
               tick(1);
               chk((i < n) ? "R9" : "R8", "gate", gate, !((i >= d + 2) && (i >= n)));
            end
            pk = 0;
            tick(2); chk("R8", "gate", gate, 1'b0);
            tick(1); chk("R8", "gate", gate, 1'b1);
         end
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule